// File: doc/BRIEF.md
# Multi-Channel DDS Waveform Oscillator

This block is a bank of direct digital synthesis oscillators. Each channel adds a 48-bit tuning word to a 48-bit phase register on every clock. The top nine phase bits select one of 512 byte-wide samples in that channel's waveform table. The selected sample is registered and driven on the channel's slice of the output bus. The output frequency is the clock frequency times the tuning word, divided by 2^48.

A byte-wide write bus programs the channels. Bits [7:4] of the address select a channel, so each channel owns a window of sixteen addresses and the windows are 0x10 apart. Bits [3:0] select a register inside the window. The tuning word is loaded one byte at a time into a holding register. It reaches the accumulator as one 48-bit value only when its most significant byte is written, so software writes the bytes from least to most significant. To rewrite the waveform table, software first sets a table pointer and then writes the data register. Table writes use their own port, so the phase accumulation and the sample stream never pause.

Every register in a channel window is write-only. A separate read port returns a fixed identification byte at address 0xE0. The output bus carries a new sample on every clock. It has no valid/ready handshake and the consumer cannot apply back-pressure; a consumer that needs flow control must decimate or buffer downstream of this block.

Top module: `dds_osc_bank`

## Requirements
- R1: While `rst` is high, every output sample is 0x00 and each channel's phase register and active tuning word are cleared. After reset, with no writes, every channel outputs table entry 0 (0x80) on every cycle.
- R2: On each clock edge out of reset, a channel's phase becomes phase + active tuning word, modulo 2^48. The sample visible after edge k is the table entry indexed by phase bits [47:39] as they were before edge k, so the output lags the phase by one clock.
- R3: Window offsets 0x0 to 0x4 load tuning bytes 0 to 4 into a holding register and do not change the active tuning word. A write to offset 0x5 makes {byte 5, held bytes 4..0} the active word, and that word is first added on the following edge.
- R4: Writes to offsets 0x6, 0x7 and 0xB to 0xF, and to any address whose bits [7:4] do not name an existing channel, change no output.
- R5: Offset 0x8 sets table pointer bits [7:0] and bit 0 of a write to offset 0x9 sets pointer bit 8. A write to offset 0xA stores the data byte in the table entry the pointer names, and the sample stream keeps running during the write.
- R6: A table data write leaves the pointer unchanged, so two data writes in a row land in the same entry and the later byte wins.
- R7: A write reaches only the channel whose index equals address bits [7:4]. Channel n owns addresses 0x10*n to 0x10*n+0xF.
- R8: One cycle after `rd_addr` is 0xE0, `rd_data` reads 0xA5. It reads 0x00 for any other address, because all channel registers are write-only.
- R9: At start-up, entry i of each table (0 <= i < 512, t = i mod 256) holds 128 + m for i < 256 and 128 - m otherwise, where m = floor(16*127*t*(256-t) / (5*65536 - 4*t*(256-t))). This is one period of a sine wave in offset binary.
- R10: A tuning word at or above 2^47 behaves as a negative step and the phase wraps through zero. For example, a word of 2^48 - 2^39 walks the table indices downward from 0 to 511, 510, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address: bits [7:4] channel, bits [3:0] offset |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Registered read data (identification byte or 0x00) |
| wave_out | output | NCH*8 | Samples; channel n on bits [8n+7:8n] |

## Verification
The bench compares every channel's sample on every cycle against a reference model. It targets the following corner cases:

- Tuning bytes written out of order with the accumulator already running. A design that updated the active word on any byte would change pitch early and drift off the model.
- A descending tuning word that crosses index 0. A design that saturated instead of wrapping, or dropped the carry, would stick at one end of the table.
- Two back-to-back table data writes with no pointer change. A pointer that auto-incremented would corrupt the neighbouring entry.
- Writes to unused offsets and to channel windows that do not exist. A decoder that aliased them would move a live channel's phase or table.
- A full sweep of all 512 start-up samples, which catches any error in the built-in sine.

// File: rtl/dds_osc_pkg.sv
package dds_osc_pkg;
  localparam logic [3:0] OFS_PTR_LO = 4'h8;
  localparam logic [3:0] OFS_PTR_HI = 4'h9;
  localparam logic [3:0] OFS_DATA   = 4'hA;
  localparam logic [7:0] SIG_VALUE  = 8'hA5;

  // One period of a sine, offset binary, rational approximation per half period.
  function automatic logic [7:0] sine_sample(input int unsigned idx, input int unsigned depth);
    longint unsigned half, t, prod, num, den, mag;
    half = longint'(depth) / 2;
    t    = longint'(idx) % half;
    prod = t * (half - t);
    num  = 16 * 127 * prod;
    den  = 5 * half * half - 4 * prod;
    mag  = num / den;
    if (longint'(idx) < half) return 8'(128 + mag);
    else                      return 8'(128 - mag);
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_osc_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [3:0]       ofs,
  input  logic [7:0]       wdata,
  output logic [IDX_W-1:0] index
);
  localparam int NBYTES  = ACC_W / 8;
  localparam int TOP_OFS = NBYTES - 1;

  logic [ACC_W-9:0] stage_q;
  logic [ACC_W-1:0] ftw_q;
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      ftw_q   <= '0;
      acc_q   <= '0;
    end else begin
      acc_q <= acc_q + ftw_q;
      if (we) begin
        for (int b = 0; b < TOP_OFS; b++)
          if (ofs == 4'(b)) stage_q[b*8 +: 8] <= wdata;
        if (ofs == 4'(TOP_OFS)) ftw_q <= {wdata, stage_q};
      end
    end
  end

  assign index = acc_q[ACC_W-1 -: IDX_W];

  AST_FTW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && ofs == 4'(TOP_OFS)) |=> $stable(ftw_q)); // R3

  AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
    (ftw_q == '0) |=> $stable(acc_q)); // R2
endmodule

// File: rtl/dds_wave_table.sv
module dds_wave_table
  import dds_osc_pkg::*;
#(
  parameter int IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = sine_sample(i, DEPTH);
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dds_channel.sv
module dds_channel
  import dds_osc_pkg::*;
#(
  parameter int ACC_W = 48,
  parameter int IDX_W = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [3:0] ofs,
  input  logic [7:0] wdata,
  output logic [7:0] wave
);
  localparam int PTR_HI_W = IDX_W - 8;

  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] rd_idx;
  logic             tbl_we;

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (we) begin
      if (ofs == OFS_PTR_LO) ptr_q[7:0] <= wdata;
      if (ofs == OFS_PTR_HI) ptr_q[IDX_W-1:8] <= wdata[PTR_HI_W-1:0];
    end
  end

  assign tbl_we = we && (ofs == OFS_DATA);

  dds_phase_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_acc (
    .clk(clk), .rst(rst), .we(we), .ofs(ofs), .wdata(wdata), .index(rd_idx)
  );

  dds_wave_table #(.IDX_W(IDX_W)) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .waddr(ptr_q), .wdata(wdata),
    .raddr(rd_idx), .rdata(wave)
  );

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(we && (ofs == OFS_PTR_LO || ofs == OFS_PTR_HI)) |=> $stable(ptr_q)); // R6
endmodule

// File: rtl/dds_osc_bank.sv
module dds_osc_bank
  import dds_osc_pkg::*;
#(
  parameter int          NCH      = 4,
  parameter int          ACC_W    = 48,
  parameter int          IDX_W    = 9,
  parameter logic [7:0]  SIG_ADDR = 8'hE0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [NCH*8-1:0] wave_out
);
  localparam int ADDR_W = 8;
  localparam int OFS_W  = 4;
  localparam int SEL_W  = ADDR_W - OFS_W;

  logic [NCH-1:0] ch_we;
  logic [7:0]     rd_q;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign ch_we[k] = wr_en && (wr_addr[ADDR_W-1:OFS_W] == SEL_W'(k));

    dds_channel #(.ACC_W(ACC_W), .IDX_W(IDX_W)) u_ch (
      .clk(clk), .rst(rst), .we(ch_we[k]), .ofs(wr_addr[OFS_W-1:0]),
      .wdata(wr_data), .wave(wave_out[k*8 +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= (rd_addr == SIG_ADDR) ? SIG_VALUE : 8'h00;
  end

  assign rd_data = rd_q;

  AST_SIG_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == SIG_ADDR) |=> (rd_data == SIG_VALUE)); // R8

  AST_ONE_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_we)); // R7
endmodule

// File: tb/dds_osc_bank_test.sv
module dds_osc_bank_test;
  localparam int NCH = 4;
  localparam int W   = NCH * 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [7:0]   rd_addr = '0;
  logic [7:0]   rd_data;
  logic [W-1:0] wave_out;

  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R1";
  bit    done = 0;

  dds_osc_bank #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .wave_out(wave_out)
  );

  always #10 clk = ~clk;

  // Reference model built from the requirements
  logic [47:0]  m_acc   [NCH];
  logic [47:0]  m_ftw   [NCH];
  logic [39:0]  m_stage [NCH];
  logic [8:0]   m_ptr   [NCH];
  logic [7:0]   m_mem   [NCH][512];
  logic [W-1:0] exp_q [$];

  function automatic logic [7:0] ref_sine(input int i);
    longint t, p, m;
    t = i % 256;
    p = t * (256 - t);
    m = (2032 * p) / (327680 - 4 * p);
    return (i < 256) ? 8'(128 + m) : 8'(128 - m);
  endfunction

  initial begin
    for (int c = 0; c < NCH; c++)
      for (int i = 0; i < 512; i++) m_mem[c][i] = ref_sine(i);
  end

  always @(posedge clk) begin
    logic [W-1:0] e;
    int c, o;
    e = '0;
    if (rst) begin
      for (int k = 0; k < NCH; k++) begin
        m_acc[k] = '0; m_ftw[k] = '0; m_stage[k] = '0; m_ptr[k] = '0;
      end
    end else begin
      for (int k = 0; k < NCH; k++) begin
        e[k*8 +: 8] = m_mem[k][m_acc[k][47:39]];
        m_acc[k] = m_acc[k] + m_ftw[k];
      end
      if (wr_en) begin
        c = int'(wr_addr[7:4]);
        o = int'(wr_addr[3:0]);
        if (c < NCH) begin
          if (o <= 4)  m_stage[c][o*8 +: 8] = wr_data;
          if (o == 5)  m_ftw[c] = {wr_data, m_stage[c]};
          if (o == 8)  m_ptr[c][7:0] = wr_data;
          if (o == 9)  m_ptr[c][8] = wr_data[0];
          if (o == 10) m_mem[c][m_ptr[c]] = wr_data;
        end
      end
    end
    exp_q.push_back(e);
  end

  // Monitor: compare each channel's sample half a cycle after the edge
  always @(negedge clk) begin
    logic [W-1:0] e;
    if (exp_q.size() > 0 && !done) begin
      e = exp_q.pop_front();
      for (int k = 0; k < NCH; k++) begin
        checks++;
        if (wave_out[k*8 +: 8] !== e[k*8 +: 8]) begin
          errors++;
          $display("FAIL %s ch%0d sample: actual %02h expected %02h", cur_tag, k,
                   wave_out[k*8 +: 8], e[k*8 +: 8]);
        end
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_ftw(input int ch, input logic [47:0] w);
    for (int b = 0; b < 6; b++) wr_reg(8'(ch * 16 + b), w[b*8 +: 8]);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [7:0] expv, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    checks++;
    if (rd_data !== expv) begin
      errors++;
      $display("FAIL %s read %02h: actual %02h expected %02h", tag, a, rd_data, expv);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    cur_tag = "R1";
    idle(3);
    rst = 1'b0;
    idle(6);

    cur_tag = "R9 R2";                 // full table sweep, one entry per clock
    set_ftw(0, 48'h0080_0000_0000);
    idle(530);

    cur_tag = "R3";                    // staged bytes must not change pitch early
    for (int b = 0; b < 5; b++) wr_reg(8'(16 + b), 8'(8'h11 * (b + 1)));
    wr_reg(8'h04, 8'h40);
    idle(12);
    wr_reg(8'h15, 8'h02);
    wr_reg(8'h05, 8'h00);
    idle(20);

    cur_tag = "R10";                   // negative step wraps through index 0
    set_ftw(2, 48'hFF80_0000_0000);
    idle(40);

    cur_tag = "R7";                    // only channel 3 should move
    set_ftw(3, 48'h0123_4567_89AB);
    idle(30);

    cur_tag = "R5 R6";                 // indirect table writes, pointer fixed
    wr_reg(8'h08, 8'h05);
    wr_reg(8'h09, 8'h01);
    wr_reg(8'h0A, 8'h3C);
    wr_reg(8'h0A, 8'h3D);
    wr_reg(8'h28, 8'hFF);
    wr_reg(8'h29, 8'h00);
    wr_reg(8'h2A, 8'h00);
    set_ftw(0, 48'h0080_0000_0000);
    idle(530);

    cur_tag = "R4";                    // ignored offsets and absent channels
    wr_reg(8'h06, 8'hFF);
    wr_reg(8'h07, 8'hFF);
    for (int o = 11; o < 16; o++) wr_reg(8'(16 + o), 8'hEE);
    wr_reg(8'h45, 8'h7F);
    wr_reg(8'h4A, 8'h00);
    wr_reg(8'hE5, 8'h33);
    wr_reg(8'hD0, 8'h99);
    idle(40);

    cur_tag = "R8";
    rd_check(8'hE0, 8'hA5, "R8");
    rd_check(8'h05, 8'h00, "R8");
    rd_check(8'hE1, 8'h00, "R8");
    rd_check(8'hE0, 8'hA5, "R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule